// File: doc/BRIEF.md
# Crossing Trigger Gate with Condition Scalers

This block makes the per-crossing fire decision for a single trigger channel. On every beam-crossing strobe it compares a 256-bit vector of input terms against two programmed masks, one listing terms that must be high and one listing terms that must be low. It then combines that match with the channel's disable sources. The disable sources fall into two families. The correlated family is the front-end busy and four global disables. The decorrelated family is a supervisor disable, a prescaler disable, an auto disable, two individual disables and four more global disables. A 16-bit obey word states which of these sources the channel follows.

When every condition allows it, the block raises a one-cycle fire pulse. A second pulse, the reject qualifier, goes out with the fire when the channel is programmed to force a second-level reject. Eleven saturating scalers count what happened on each crossing: whether the and-or match held, four enable conditions over different subsets of the disables, each disable source on its own, and the fires. Software selects one scaler at a time for reading and can clear all of them in one cycle.

Top module: `xgate_top`

## Requirements
- R1: The and-or match holds when every term whose bit is set in `req_hi` is 1 and every term whose bit is set in `req_lo` is 0. Bit i of each mask refers to `terms[i]`. Scaler 0 counts strobes on which the match holds.
- R2: Obey word layout. Bit 0 set means the channel is disabled by the supervisor. Bit 1 obeys `presc_dis` and bit 2 obeys `auto_dis`. Bits 5:4 obey `indiv_dis[1:0]`, bits 11:8 obey `corr_dis[3:0]` and bits 15:12 obey `decorr_dis[3:0]`. A disable input whose obey bit is 0 has no effect, and bits 3, 6 and 7 have no effect.
- R3: `fire` is high for exactly the one cycle after a clock edge at which `xing` was 1 and the exposed condition held. The exposed condition requires `fe_busy` low, no obeyed correlated or decorrelated global disable, no supervisor disable, no obeyed individual, prescaler or auto disable, and the and-or match. Without a strobe, `fire` stays 0.
- R4: `fire_rej` is high in exactly the cycles where `fire` is high and `force_rej_cfg` was 1 at the deciding edge.
- R5: Scaler 1 (exposed) and scaler 10 (fired) count strobes on which the exposed condition held.
- R6: Scaler 2 (acquisition enable) counts strobes on which all the exposed conditions except the and-or match held.
- R7: Scaler 3 (decorrelated enable) counts strobes with no supervisor disable, no obeyed auto, prescaler or individual disable, and no obeyed decorrelated global disable. The correlated inputs and the match do not affect it.
- R8: Scaler 4 (correlated enable) counts strobes with `fe_busy` low and no obeyed correlated global disable. No other input affects it.
- R9: Scalers 5 and 6 count strobes on which individual disable 0 or 1, respectively, is asserted and obeyed. Scalers 7 and 8 do the same for the prescaler and auto disables. Scaler 9 counts strobes with obey bit 0 set.
- R10: All scalers are 0 after reset and change only at an edge where `xing` or `clr` is 1. `rd_data` shows the scaler chosen by `rd_sel` combinationally, so an increment is visible in the cycle after the edge. Values of `rd_sel` from 11 to 15 read 0.
- R11: `clr` set at an edge makes every scaler 0 after that edge, even when the same edge carries an increment.
- R12: A scaler that has reached 2^SCALER_W-1 stays there on further increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing | input | 1 | Beam-crossing strobe, one cycle per crossing |
| terms | input | N_TERMS | And-or input term vector |
| req_hi | input | N_TERMS | Terms required high |
| req_lo | input | N_TERMS | Terms required low (veto) |
| obey | input | 16 | Obey word, layout in R2 |
| force_rej_cfg | input | 1 | Channel forces a second-level reject |
| fe_busy | input | 1 | Exposure-group front-end busy |
| corr_dis | input | 4 | Correlated global disables |
| decorr_dis | input | 4 | Decorrelated global disables |
| indiv_dis | input | 2 | Individual disables |
| presc_dis | input | 1 | Prescaler disable |
| auto_dis | input | 1 | Auto disable |
| clr | input | 1 | Synchronous clear of all scalers |
| rd_sel | input | 4 | Scaler select, map in R1 and R5 to R9 |
| fire | output | 1 | Fire pulse |
| fire_rej | output | 1 | Reject qualifier sent with the fire |
| rd_data | output | SCALER_W | Selected scaler value |

## Verification
The hardest state to reach is a saturated scaler. A 64-bit counter never fills in a simulation of practical length. For that reason the bench runs a second copy of the block with 3-bit scalers beside the 64-bit one, on the same stimulus. The narrow copy must always read the wide copy's expected count capped at 7, so saturation, clearing and the increment that coincides with a clear are all exercised on every check. A second hard case is a disable that is asserted but not obeyed, since it must leave every count unchanged. The random stimulus draws the obey bits and the disables independently, and directed crossings set each unobeyed source on its own.

// File: rtl/xgate_pkg.sv
package xgate_pkg;
   // obey word layout
   localparam int OBEY_W     = 16;
   localparam int OB_SUPV    = 0;
   localparam int OB_PRESC   = 1;
   localparam int OB_AUTO    = 2;
   localparam int OB_INDIV0  = 4;
   localparam int OB_CORR0   = 8;
   localparam int OB_DECORR0 = 12;
   localparam int N_INDIV    = 2;
   localparam int N_GLOB     = 4;

   // scaler index map (also the read select map)
   localparam int SC_ANDOR   = 0;
   localparam int SC_EXPOSED = 1;
   localparam int SC_DAQ     = 2;
   localparam int SC_DECORR  = 3;
   localparam int SC_CORR    = 4;
   localparam int SC_INDIV0  = 5;
   localparam int SC_INDIV1  = 6;
   localparam int SC_PRESC   = 7;
   localparam int SC_AUTO    = 8;
   localparam int SC_SUPV    = 9;
   localparam int SC_FIRED   = 10;
   localparam int N_SCALERS  = 11;
   localparam int SEL_W      = $clog2(N_SCALERS);

   // per-crossing condition summary
   typedef struct packed {
      logic                andor_ok;
      logic                corr_en;
      logic                decorr_en;
      logic                daq_en;
      logic                exposed;
      logic [N_INDIV-1:0]  indiv_hit;
      logic                presc_hit;
      logic                auto_hit;
      logic                supv_hit;
   } gate_t;
endpackage

// File: rtl/xgate_andor.sv
module xgate_andor #(
   parameter int N_TERMS = 256,
   parameter int CHUNK_W = 32
) (
   input  logic [N_TERMS-1:0] terms,
   input  logic [N_TERMS-1:0] req_hi,
   input  logic [N_TERMS-1:0] req_lo,
   output logic               andor_ok
);
   localparam int N_CHUNK = N_TERMS / CHUNK_W;

   if (CHUNK_W < 1 || N_TERMS % CHUNK_W != 0) begin : g_bad_chunk
      $error("xgate_andor: N_TERMS must be a multiple of CHUNK_W");
   end

   logic [N_CHUNK-1:0] chunk_ok;

   // each slice checks its own terms; the results are then AND-reduced
   for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
      logic [CHUNK_W-1:0] t_s, hi_s, lo_s;
      assign t_s  = terms [c*CHUNK_W +: CHUNK_W];
      assign hi_s = req_hi[c*CHUNK_W +: CHUNK_W];
      assign lo_s = req_lo[c*CHUNK_W +: CHUNK_W];
      assign chunk_ok[c] = &(t_s | ~hi_s) & ~|(t_s & lo_s);
   end

   assign andor_ok = &chunk_ok;
endmodule

// File: rtl/xgate_cond.sv
module xgate_cond
   import xgate_pkg::*;
(
   input  logic [OBEY_W-1:0]  obey,
   input  logic               andor_ok,
   input  logic               fe_busy,
   input  logic [N_GLOB-1:0]  corr_dis,
   input  logic [N_GLOB-1:0]  decorr_dis,
   input  logic [N_INDIV-1:0] indiv_dis,
   input  logic               presc_dis,
   input  logic               auto_dis,
   output gate_t              gate
);
   logic corr_blk, decorr_blk;
   logic unused_obey;

   // obey bits 3, 6 and 7 carry no meaning
   assign unused_obey = ^{obey[3], obey[7:6]};

   assign corr_blk   = |(corr_dis   & obey[OB_CORR0   +: N_GLOB]);
   assign decorr_blk = |(decorr_dis & obey[OB_DECORR0 +: N_GLOB]);

   always_comb begin
      gate.andor_ok  = andor_ok;
      gate.indiv_hit = indiv_dis & obey[OB_INDIV0 +: N_INDIV];
      gate.presc_hit = presc_dis & obey[OB_PRESC];
      gate.auto_hit  = auto_dis  & obey[OB_AUTO];
      gate.supv_hit  = obey[OB_SUPV];
      gate.corr_en   = !fe_busy && !corr_blk;
      gate.decorr_en = !gate.supv_hit && !gate.presc_hit && !gate.auto_hit &&
                       !(|gate.indiv_hit) && !decorr_blk;
      gate.daq_en    = gate.corr_en && gate.decorr_en;
      gate.exposed   = gate.daq_en && andor_ok;
   end
endmodule

// File: rtl/xgate_scaler_bank.sv
module xgate_scaler_bank #(
   parameter int SCALER_W = 64,
   parameter int N_SC     = 11,
   parameter int SEL_W    = 4,
   parameter bit READ_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strobe,
   input  logic                clr,
   input  logic [N_SC-1:0]     inc,
   input  logic [SEL_W-1:0]    rd_sel,
   output logic [SCALER_W-1:0] rd_data
);
   localparam logic [SCALER_W-1:0] SAT_MAX = '1;

   if (SCALER_W < 2) begin : g_bad_w
      $error("xgate_scaler_bank: SCALER_W must be at least 2");
   end
   if (N_SC > (1 << SEL_W)) begin : g_bad_sel
      $error("xgate_scaler_bank: SEL_W too narrow for N_SC");
   end

   logic [SCALER_W-1:0] cnt [N_SC];
   logic [SCALER_W-1:0] rd_mux;

   for (genvar i = 0; i < N_SC; i++) begin : g_sc
      always_ff @(posedge clk) begin
         if (!rst_n || clr)                           cnt[i] <= '0;
         else if (strobe && inc[i] && cnt[i] != SAT_MAX) cnt[i] <= cnt[i] + 1'b1;
      end

      AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> cnt[i] == '0);                                          // R11
      AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> cnt[i] >= $past(cnt[i]));                               // R12
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!strobe && !clr) |=> $stable(cnt[i]));                          // R10
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < N_SC; k++)
         if (rd_sel == SEL_W'(k)) rd_mux = cnt[k];
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_mux;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end
endmodule

// File: rtl/xgate_top.sv
module xgate_top
   import xgate_pkg::*;
#(
   parameter int N_TERMS  = 256,
   parameter int CHUNK_W  = 32,
   parameter int SCALER_W = 64,
   parameter bit READ_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                xing,
   input  logic [N_TERMS-1:0]  terms,
   input  logic [N_TERMS-1:0]  req_hi,
   input  logic [N_TERMS-1:0]  req_lo,
   input  logic [15:0]         obey,
   input  logic                force_rej_cfg,
   input  logic                fe_busy,
   input  logic [3:0]          corr_dis,
   input  logic [3:0]          decorr_dis,
   input  logic [1:0]          indiv_dis,
   input  logic                presc_dis,
   input  logic                auto_dis,
   input  logic                clr,
   input  logic [3:0]          rd_sel,
   output logic                fire,
   output logic                fire_rej,
   output logic [SCALER_W-1:0] rd_data
);
   if (OBEY_W != 16 || SEL_W != 4) begin : g_bad_layout
      $error("xgate_top: package layout does not match port widths");
   end

   logic               andor_ok;
   gate_t              gate;
   logic [N_SCALERS-1:0] inc;

   xgate_andor #(.N_TERMS(N_TERMS), .CHUNK_W(CHUNK_W)) i_andor (
      .terms(terms), .req_hi(req_hi), .req_lo(req_lo), .andor_ok(andor_ok));

   xgate_cond i_cond (
      .obey(obey), .andor_ok(andor_ok), .fe_busy(fe_busy),
      .corr_dis(corr_dis), .decorr_dis(decorr_dis), .indiv_dis(indiv_dis),
      .presc_dis(presc_dis), .auto_dis(auto_dis), .gate(gate));

   always_comb begin
      inc             = '0;
      inc[SC_ANDOR]   = gate.andor_ok;
      inc[SC_EXPOSED] = gate.exposed;
      inc[SC_DAQ]     = gate.daq_en;
      inc[SC_DECORR]  = gate.decorr_en;
      inc[SC_CORR]    = gate.corr_en;
      inc[SC_INDIV0]  = gate.indiv_hit[0];
      inc[SC_INDIV1]  = gate.indiv_hit[1];
      inc[SC_PRESC]   = gate.presc_hit;
      inc[SC_AUTO]    = gate.auto_hit;
      inc[SC_SUPV]    = gate.supv_hit;
      inc[SC_FIRED]   = gate.exposed;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fire     <= 1'b0;
         fire_rej <= 1'b0;
      end else begin
         fire     <= xing && gate.exposed;
         fire_rej <= xing && gate.exposed && force_rej_cfg;
      end
   end

   xgate_scaler_bank #(.SCALER_W(SCALER_W), .N_SC(N_SCALERS), .SEL_W(SEL_W),
                       .READ_REG(READ_REG)) i_bank (
      .clk(clk), .rst_n(rst_n), .strobe(xing), .clr(clr), .inc(inc),
      .rd_sel(rd_sel), .rd_data(rd_data));

   AST_FIRE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(xing));                                              // R3
   AST_FIRE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !$past(fe_busy));                                          // R3
   AST_FIRE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(andor_ok));                                          // R1
   AST_REJ_WITH_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_rej |-> fire);                                                 // R4
   AST_REJ_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> fire_rej == $past(force_rej_cfg));                         // R4
endmodule

// File: tb/test_xgate_top.sv
`timescale 1ns/1ps
module test_xgate_top;
   localparam int NT = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          xing = 1'b0;
   logic [NT-1:0] terms = '0, req_hi = '0, req_lo = '0;
   logic [15:0]   obey = '0;
   logic          force_rej_cfg = 1'b0, fe_busy = 1'b0;
   logic [3:0]    corr_dis = '0, decorr_dis = '0;
   logic [1:0]    indiv_dis = '0;
   logic          presc_dis = 1'b0, auto_dis = 1'b0, clr = 1'b0;
   logic [3:0]    rd_sel = '0;
   logic          fire, fire_rej, fire_n, fire_rej_n;
   logic [63:0]   rd_data;
   logic [2:0]    rd_data_n;

   int total = 0, bad = 0;
   bit done = 0;
   longint unsigned exp_sc [11];

   always #10 clk = ~clk;

   xgate_top i_xgate_top (
      .clk(clk), .rst_n(rst_n), .xing(xing), .terms(terms), .req_hi(req_hi),
      .req_lo(req_lo), .obey(obey), .force_rej_cfg(force_rej_cfg),
      .fe_busy(fe_busy), .corr_dis(corr_dis), .decorr_dis(decorr_dis),
      .indiv_dis(indiv_dis), .presc_dis(presc_dis), .auto_dis(auto_dis),
      .clr(clr), .rd_sel(rd_sel), .fire(fire), .fire_rej(fire_rej),
      .rd_data(rd_data));

   xgate_top #(.SCALER_W(3)) i_xgate_top_narrow (
      .clk(clk), .rst_n(rst_n), .xing(xing), .terms(terms), .req_hi(req_hi),
      .req_lo(req_lo), .obey(obey), .force_rej_cfg(force_rej_cfg),
      .fe_busy(fe_busy), .corr_dis(corr_dis), .decorr_dis(decorr_dis),
      .indiv_dis(indiv_dis), .presc_dis(presc_dis), .auto_dis(auto_dis),
      .clr(clr), .rd_sel(rd_sel), .fire(fire_n), .fire_rej(fire_rej_n),
      .rd_data(rd_data_n));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, expv);
      end
   endtask

   // expected increment vector, indexed by the scaler map of the requirements
   function automatic logic [10:0] model_inc();
      logic ao, c_ok, d_ok;
      logic [10:0] v;
      ao   = ((terms & req_hi) == req_hi) && ((terms & req_lo) == '0);
      c_ok = !fe_busy && ((corr_dis & obey[11:8]) == 4'h0);
      d_ok = !obey[0] && !(presc_dis && obey[1]) && !(auto_dis && obey[2]) &&
             ((indiv_dis & obey[5:4]) == 2'b00) && ((decorr_dis & obey[15:12]) == 4'h0);
      v     = '0;
      v[0]  = ao;
      v[1]  = ao && c_ok && d_ok;
      v[2]  = c_ok && d_ok;
      v[3]  = d_ok;
      v[4]  = c_ok;
      v[5]  = indiv_dis[0] && obey[4];
      v[6]  = indiv_dis[1] && obey[5];
      v[7]  = presc_dis && obey[1];
      v[8]  = auto_dis && obey[2];
      v[9]  = obey[0];
      v[10] = v[1];
      return v;
   endfunction

   function automatic string tag_of(input int idx);
      case (idx)
         0: return "R1";
         1, 10: return "R5";
         2: return "R6";
         3: return "R7";
         4: return "R8";
         5, 6, 7, 8, 9: return "R9";
         default: return "R10";
      endcase
   endfunction

   // one clock step from a falling edge to the next, with or without a strobe
   task automatic step(input logic strobe, input logic do_clr);
      logic [10:0] v;
      v    = model_inc();
      xing = strobe;
      clr  = do_clr;
      @(posedge clk);
      @(negedge clk);
      chk("R3", {63'd0, fire}, {63'd0, strobe & v[1]});
      chk("R4", {63'd0, fire_rej}, {63'd0, strobe & v[1] & force_rej_cfg});
      for (int k = 0; k < 11; k++) begin
         if (do_clr) exp_sc[k] = 0;
         else if (strobe && v[k] && exp_sc[k] != 64'hFFFF_FFFF_FFFF_FFFF) exp_sc[k]++;
      end
      xing = 1'b0;
      clr  = 1'b0;
   endtask

   task automatic check_scalers();
      for (int k = 0; k < 16; k++) begin
         longint unsigned e;
         e = (k < 11) ? exp_sc[k] : 0;
         rd_sel = 4'(k);
         #1;
         chk(tag_of(k), rd_data, e);
         chk("R12", {61'd0, rd_data_n}, (e > 7) ? 64'd7 : e);
      end
   endtask

   task automatic quiet_inputs();
      terms = '0; req_hi = '0; req_lo = '0; obey = '0;
      fe_busy = 0; corr_dis = '0; decorr_dis = '0; indiv_dis = '0;
      presc_dis = 0; auto_dis = 0; force_rej_cfg = 0;
   endtask

   task automatic rand_inputs();
      for (int k = 0; k < 8; k++) begin
         terms [k*32 +: 32] = $urandom;
         req_hi[k*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
         req_lo[k*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      end
      req_lo &= ~req_hi;
      if ($urandom % 2 == 0) terms = (terms | req_hi) & ~req_lo;
      obey       = 16'($urandom) & 16'($urandom);
      if ($urandom % 3 != 0) obey[0] = 1'b0;
      fe_busy    = ($urandom % 4 == 0);
      corr_dis   = 4'($urandom) & 4'($urandom);
      decorr_dis = 4'($urandom) & 4'($urandom);
      indiv_dis  = 2'($urandom) & 2'($urandom);
      presc_dis  = ($urandom % 4 == 0);
      auto_dis   = ($urandom % 4 == 0);
      force_rej_cfg = $urandom % 2;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R3 watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2468));
      for (int k = 0; k < 11; k++) exp_sc[k] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // reset state, R10
      chk("R3", {63'd0, fire}, 64'd0);
      check_scalers();

      // open channel: empty masks, nothing obeyed
      step(1'b1, 1'b0);
      // idle cycles leave scalers untouched, R10
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      check_scalers();

      // unused obey bits have no effect, R2
      obey = 16'h00C8;
      step(1'b1, 1'b0);
      // each disable asserted but not obeyed, R2
      obey = '0;
      corr_dis = 4'hF; decorr_dis = 4'hF; indiv_dis = 2'b11;
      presc_dis = 1; auto_dis = 1;
      step(1'b1, 1'b0);
      // now obeyed one at a time
      for (int b = 1; b < 16; b++) begin
         if (b == 3 || b == 6 || b == 7) continue;
         obey = 16'(1) << b;
         step(1'b1, 1'b0);
      end
      quiet_inputs();
      obey = 16'h0001;               // supervisor disable, R2 and R9
      step(1'b1, 1'b0);
      quiet_inputs();
      fe_busy = 1;                   // correlated only, R8
      step(1'b1, 1'b0);
      quiet_inputs();
      // and-or match corner: lowest and highest term, R1
      req_hi[0] = 1; req_lo[NT-1] = 1; terms[0] = 1; terms[NT-1] = 0;
      force_rej_cfg = 1;             // R4
      step(1'b1, 1'b0);
      terms[NT-1] = 1;
      step(1'b1, 1'b0);
      terms[NT-1] = 0; terms[0] = 0;
      step(1'b1, 1'b0);
      check_scalers();

      // drive past the narrow scaler limit, R12
      quiet_inputs();
      for (int n = 0; n < 9; n++) step(1'b1, 1'b0);
      check_scalers();

      // clear coinciding with an increment, R11
      step(1'b1, 1'b1);
      rd_sel = 4'd1;
      #1;
      chk("R11", rd_data, 64'd0);
      check_scalers();

      // random traffic
      for (int n = 0; n < 1500; n++) begin
         rand_inputs();
         step($urandom % 4 != 0, $urandom % 97 == 0);
         if (n % 100 == 99) check_scalers();
      end
      check_scalers();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule